// File: doc/BRIEF.md
# Condition Register Field File

This block stores a 32-bit condition register split into eight 4-bit fields. Every port selects fields through an 8-bit enable mask rather than a binary index. Each single-field port gives a valid flag and a 3-bit field number, and the block turns that number into a one-hot mask internally. A whole-register port takes a multi-hot mask directly, so any subset of fields can be read or written in one access.

Mask numbering runs backwards from field numbering. Field 0 is the most significant nibble, and it is enabled by the most significant mask bit. An execution pipeline uses the block as its condition register file. It can have three single-field operands read, a masked whole-register read, a single-field result write and a masked whole-register write all active in the same cycle.

Top module: `cr_field_file`

## Requirements
- R1: Field n (n = 0..7) occupies register bits [31-4n : 28-4n]. A field number n selects mask bit 7-n, so mask bit k covers register bits [4k+3 : 4k].
- R2: Read ports A, B and C are independent and combinational. When a port's valid flag is high, its 4-bit data output shows the field named by its 3-bit select.
- R3: A single-field read port whose valid flag is low outputs 0000, whatever its select is.
- R4: When the whole-register read is valid, it returns the 32-bit register with every field whose mask bit is clear forced to zero. When it is not valid, it returns all zeros.
- R5: On a rising clock edge with the single-field write valid, the selected field takes the 4-bit write data and all other fields keep their values.
- R6: On a rising clock edge with the masked write valid, every field whose mask bit is set takes the matching nibble of the 32-bit write data. Fields with a clear mask bit are unchanged. A write port with its valid flag low changes nothing.
- R7: If both write ports target the same field in one cycle, that field takes the single-field data. The other fields enabled in the mask are still written from the masked data.
- R8: Reads in a cycle that also writes return the value held before the clock edge.
- R9: A high reset, sampled on a rising edge, clears all eight fields to zero and overrides any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_vld | input | 1 | Read port A enable |
| rd_a_sel | input | 3 | Read port A field number |
| rd_a_data | output | 4 | Read port A field value |
| rd_b_vld | input | 1 | Read port B enable |
| rd_b_sel | input | 3 | Read port B field number |
| rd_b_data | output | 4 | Read port B field value |
| rd_c_vld | input | 1 | Read port C enable |
| rd_c_sel | input | 3 | Read port C field number |
| rd_c_data | output | 4 | Read port C field value |
| rd_all_vld | input | 1 | Whole-register read enable |
| rd_all_mask | input | 8 | Whole-register read field mask (bit k = nibble k) |
| rd_all_data | output | 32 | Masked register contents |
| wr_one_vld | input | 1 | Single-field write enable |
| wr_one_sel | input | 3 | Single-field write field number |
| wr_one_data | input | 4 | Single-field write value |
| wr_all_vld | input | 1 | Masked write enable |
| wr_all_mask | input | 8 | Masked write field mask (bit k = nibble k) |
| wr_all_data | input | 32 | Masked write value |

## Verification
The bench targets the reversed mapping from field number to mask bit. A design that drops the inversion writes or reads the mirror-image nibble, and a check of every field through every read port exposes it. All 256 write masks are swept and checked against a bench model, which catches a mask that leaks into neighbouring fields or is ignored when valid is low. Same-field collisions between the two write ports check that the single-field value wins without blocking the rest of the mask. Reads in write cycles show whether the design forwards new data when it should return the old value. Reset is applied together with active writes to confirm that clearing wins.

// File: rtl/cr_field_file.sv
module cr_field_file #(
  parameter int NF = 8,
  parameter int FW = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_a_vld,
  input  logic [$clog2(NF)-1:0]     rd_a_sel,
  output logic [FW-1:0]             rd_a_data,
  input  logic                      rd_b_vld,
  input  logic [$clog2(NF)-1:0]     rd_b_sel,
  output logic [FW-1:0]             rd_b_data,
  input  logic                      rd_c_vld,
  input  logic [$clog2(NF)-1:0]     rd_c_sel,
  output logic [FW-1:0]             rd_c_data,
  input  logic                      rd_all_vld,
  input  logic [NF-1:0]             rd_all_mask,
  output logic [NF*FW-1:0]          rd_all_data,
  input  logic                      wr_one_vld,
  input  logic [$clog2(NF)-1:0]     wr_one_sel,
  input  logic [FW-1:0]             wr_one_data,
  input  logic                      wr_all_vld,
  input  logic [NF-1:0]             wr_all_mask,
  input  logic [NF*FW-1:0]          wr_all_data
);
  localparam int SW = $clog2(NF);
  localparam int W  = NF * FW;
  localparam logic [SW-1:0] TOP = SW'(NF - 1);

  logic [W-1:0]  cr_q;
  logic [NF-1:0] m_a, m_b, m_c, m_rd, m_one, m_all;

  function automatic logic [NF-1:0] to_unary(input logic v, input logic [SW-1:0] s);
    to_unary = '0;
    if (v) to_unary[TOP - s] = 1'b1;
  endfunction

  function automatic logic [FW-1:0] pick(input logic [NF-1:0] m, input logic [W-1:0] r);
    pick = '0;
    for (int k = 0; k < NF; k++)
      if (m[k]) pick = pick | r[k*FW +: FW];
  endfunction

  assign m_a   = to_unary(rd_a_vld, rd_a_sel);
  assign m_b   = to_unary(rd_b_vld, rd_b_sel);
  assign m_c   = to_unary(rd_c_vld, rd_c_sel);
  assign m_one = to_unary(wr_one_vld, wr_one_sel);
  assign m_rd  = rd_all_vld ? rd_all_mask : '0;
  assign m_all = wr_all_vld ? wr_all_mask : '0;

  assign rd_a_data = pick(m_a, cr_q);
  assign rd_b_data = pick(m_b, cr_q);
  assign rd_c_data = pick(m_c, cr_q);

  always_ff @(posedge clk) begin
    if (rst) cr_q <= '0;
    else
      for (int k = 0; k < NF; k++) begin
        if (m_one[k])      cr_q[k*FW +: FW] <= wr_one_data;
        else if (m_all[k]) cr_q[k*FW +: FW] <= wr_all_data[k*FW +: FW];
      end
  end

  for (genvar k = 0; k < NF; k++) begin : g_fld
    assign rd_all_data[k*FW +: FW] = m_rd[k] ? cr_q[k*FW +: FW] : '0;

    a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
      (wr_one_vld && wr_one_sel == SW'(NF-1-k)) |=> cr_q[k*FW +: FW] == $past(wr_one_data));
    a_r7_masked_write: assert property (@(posedge clk) disable iff (rst)
      (wr_all_vld && wr_all_mask[k] && !(wr_one_vld && wr_one_sel == SW'(NF-1-k)))
      |=> cr_q[k*FW +: FW] == $past(wr_all_data[k*FW +: FW]));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (!(wr_all_vld && wr_all_mask[k]) && !(wr_one_vld && wr_one_sel == SW'(NF-1-k)))
      |=> $stable(cr_q[k*FW +: FW]));
    a_r4_unmasked_zero: assert property (@(posedge clk) disable iff (rst)
      !(rd_all_vld && rd_all_mask[k]) |-> rd_all_data[k*FW +: FW] == '0);
  end

  a_r3_idle_read: assert property (@(posedge clk) disable iff (rst)
    (!rd_a_vld |-> rd_a_data == '0) and (!rd_b_vld |-> rd_b_data == '0)
    and (!rd_c_vld |-> rd_c_data == '0));
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> cr_q == '0);
  a_r1_onehot_sel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_one) && $onehot0(m_a));
endmodule

// File: tb/cr_field_file_tb.sv
module cr_field_file_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic rd_a_vld = 0, rd_b_vld = 0, rd_c_vld = 0, rd_all_vld = 0;
  logic [2:0] rd_a_sel = 0, rd_b_sel = 0, rd_c_sel = 0, wr_one_sel = 0;
  logic [3:0] rd_a_data, rd_b_data, rd_c_data, wr_one_data = 0;
  logic [7:0] rd_all_mask = 0, wr_all_mask = 0;
  logic [31:0] rd_all_data, wr_all_data = 0;
  logic wr_one_vld = 0, wr_all_vld = 0;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] model = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  cr_field_file dut_i (
    .clk(clk), .rst(rst),
    .rd_a_vld(rd_a_vld), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_vld(rd_b_vld), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .rd_c_vld(rd_c_vld), .rd_c_sel(rd_c_sel), .rd_c_data(rd_c_data),
    .rd_all_vld(rd_all_vld), .rd_all_mask(rd_all_mask), .rd_all_data(rd_all_data),
    .wr_one_vld(wr_one_vld), .wr_one_sel(wr_one_sel), .wr_one_data(wr_one_data),
    .wr_all_vld(wr_all_vld), .wr_all_mask(wr_all_mask), .wr_all_data(wr_all_data));

  function automatic logic [3:0] fld(input logic [31:0] r, input int n);
    return r[31-4*n -: 4];
  endfunction

  function automatic logic [31:0] expand(input logic [7:0] m);
    logic [31:0] e = '0;
    for (int k = 0; k < 8; k++) if (m[k]) e[4*k +: 4] = 4'hF;
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
  endtask

  // Bench model of the next register value (field n = nibble 7-n, R1/R5/R6/R7/R9)
  task automatic step();
    logic [31:0] nx = model;
    if (rst) nx = '0;
    else begin
      if (wr_all_vld) nx = (model & ~expand(wr_all_mask)) | (wr_all_data & expand(wr_all_mask));
      if (wr_one_vld) nx[31-4*wr_one_sel -: 4] = wr_one_data;
    end
    @(posedge clk);
    model = nx;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_one_vld = 0; wr_all_vld = 0;
  endtask

  task automatic read_all_fields(input string req);
    rd_a_vld = 1; rd_b_vld = 1; rd_c_vld = 1; rd_all_vld = 1; rd_all_mask = 8'hFF;
    for (int n = 0; n < 8; n++) begin
      rd_a_sel = 3'(n); rd_b_sel = 3'((n+3)%8); rd_c_sel = 3'((n+5)%8);
      #1;
      chk({req, " R2 portA"}, {28'b0, rd_a_data}, {28'b0, fld(model, n)});
      chk({req, " R2 portB"}, {28'b0, rd_b_data}, {28'b0, fld(model, (n+3)%8)});
      chk({req, " R2 portC"}, {28'b0, rd_c_data}, {28'b0, fld(model, (n+5)%8)});
    end
    chk({req, " R4 full"}, rd_all_data, model);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    step();
    rst = 0;
    rd_all_vld = 1; rd_all_mask = 8'hFF; #1;
    chk("R9 reset state", rd_all_data, 32'h0);

    // R1/R5: single-field write of each field, mask bit 7-n
    for (int n = 0; n < 8; n++) begin
      wr_one_vld = 1; wr_one_sel = 3'(n); wr_one_data = 4'(n + 9);
      step();
      idle();
      rd_all_mask = 8'h80 >> n; #1;
      chk("R1 field position", rd_all_data, {28'b0, 4'(n + 9)} << (28 - 4*n));
    end
    read_all_fields("R5 after singles");

    // R3: invalid reads give zero
    rd_a_vld = 0; rd_b_vld = 0; rd_c_vld = 0; rd_all_vld = 0;
    for (int n = 0; n < 8; n++) begin
      rd_a_sel = 3'(n); rd_b_sel = 3'(n); rd_c_sel = 3'(n); rd_all_mask = 8'hFF; #1;
      chk("R3 idle A", {28'b0, rd_a_data}, 32'h0);
      chk("R3 idle B", {28'b0, rd_b_data}, 32'h0);
      chk("R3 idle C", {28'b0, rd_c_data}, 32'h0);
      chk("R4 invalid whole read", rd_all_data, 32'h0);
    end

    // R6: sweep all masked-write masks, plus R4 random read masks and R8
    for (int m = 0; m < 256; m++) begin
      rnd();
      wr_all_vld = 1; wr_all_mask = 8'(m); wr_all_data = lcg;
      rd_all_vld = 1; rd_all_mask = 8'hFF; #1;
      chk("R8 old value during write", rd_all_data, model);
      step();
      idle();
      chk("R6 masked write", rd_all_data, model);
      rnd();
      rd_all_mask = lcg[7:0]; #1;
      chk("R4 partial read", rd_all_data, model & expand(lcg[7:0]));
    end

    // R6: write ports with valid low change nothing
    for (int m = 0; m < 8; m++) begin
      rnd();
      wr_all_vld = 0; wr_all_mask = 8'hFF; wr_all_data = ~model;
      wr_one_vld = 0; wr_one_sel = 3'(m); wr_one_data = ~fld(model, m);
      step();
      rd_all_vld = 1; rd_all_mask = 8'hFF; #1;
      chk("R6 invalid write ignored", rd_all_data, model);
    end

    // R7: collisions on every field
    for (int n = 0; n < 8; n++) begin
      rnd();
      wr_all_vld = 1; wr_all_mask = 8'hFF; wr_all_data = lcg;
      wr_one_vld = 1; wr_one_sel = 3'(n); wr_one_data = ~lcg[31-4*n -: 4];
      step();
      idle();
      rd_all_mask = 8'hFF; #1;
      chk("R7 collision", rd_all_data, model);
      rd_a_vld = 1; rd_a_sel = 3'(n); #1;
      chk("R7 single wins", {28'b0, rd_a_data}, {28'b0, ~lcg[31-4*n -: 4]});
    end
    read_all_fields("R8 final");

    // R9: reset overrides concurrent writes
    rst = 1; wr_all_vld = 1; wr_all_mask = 8'hFF; wr_all_data = 32'hFFFF_FFFF;
    wr_one_vld = 1; wr_one_sel = 3'd2; wr_one_data = 4'hF;
    step();
    rst = 0; idle();
    rd_all_vld = 1; rd_all_mask = 8'hFF; #1;
    chk("R9 reset over write", rd_all_data, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule